// File: doc/BRIEF.md
# Verified Register-Read SPI Slave

This block is a byte-oriented SPI slave (clock idle low, data captured on the rising clock edge, most significant bit first) that answers register reads from a 32-entry register file. A read is guarded by a round-trip check. The slave returns the header, streams the requested bytes, and takes the same bytes back from the master. It then repeats the header and closes with a one-byte verdict: a pass code when everything agreed, or the bitwise inverse of that code when anything went wrong.

The SPI pins are oversampled by the system clock through a short synchronizer. All state therefore lives in one clock domain. The register file sits outside the block and is reached through a combinational read port: `rdData` must reflect `rdAddr` in the same cycle. A two-bit strap input lets four slaves share one master. A header whose device field differs from the strap, or whose read bit is clear, is ignored for the rest of that selection.

Top module: `vreg_read_slave`

## Requirements
- R1: While chip select is high, `spiMiso` is 0. Raising chip select returns the bit counter, byte counter and transaction state to idle.
- R2: The first byte is the header. Bits 7:6 are the device field, bits 5:1 the start register, and bit 0 is 1 for a read. If the device field differs from `devId`, or bit 0 is 0, `spiMiso` stays 0 until chip select rises.
- R3: During the second byte the slave shifts out the header byte exactly as received. The master's byte in that slot is ignored.
- R4: Data bytes are read from the start register and then consecutive registers, wrapping from 31 to 0. The first data byte is sent during the third byte.
- R5: The master's third byte is the count code. Bits 7:4 hold N-1, where N is the number of data bytes, and bits 3:0 must hold the inverse of bits 7:4 (one byte is 0x0F). Data bytes occupy byte slots 2 to N+1.
- R6: A count code whose low nibble is not the inverse of its high nibble makes the verdict 0xA6.
- R7: While the master echoes the N data bytes, the slave sends 0. In the byte after the echo it sends the header byte again.
- R8: In the next byte the master sends 0x59. The slave answers 0x59 if every echoed byte matched and the count code was valid, and answers 0xA6 otherwise.
- R9: During the verdict byte, each received bit is compared with the bit being driven. From the first disagreement on (for example, after an extra clock pulse), the remaining bits come from 0xA6 at their bit positions.
- R10: If the master raises chip select right after the data bytes, the slave returns to idle, and the next full read completes with the pass code.
- R11: After the verdict byte, `spiMiso` is 0 until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| devId | input | 2 | Strapped device number compared with the header |
| spiClk | input | 1 | SPI serial clock, idle low |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data from the master |
| spiMiso | output | 1 | Serial data to the master |
| rdAddr | output | 5 | Register file read address |
| rdData | input | 8 | Register file read data for `rdAddr` |

## Verification
Some properties are checked on every cycle. The output stays quiet after chip select has been high for several cycles, and it stays quiet in an ignored transaction. The byte index never passes the decoded count during streaming or echo. The captured header does not change once decoding has moved on, and an error flag, once raised, persists until deselection. The bench scenarios cover the rest. These are the exact byte sequences seen by the master, the wrap of the register address, the verdict for a bad count code, a corrupted echo and an injected clock spike, and recovery after an early release.

// File: rtl/vreg_read_pkg.sv
package vreg_read_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 2;
  localparam int REG_AW = 5;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    PH_HDR, PH_ADDR, PH_DATA, PH_ECHO, PH_ADDR2, PH_CTRL, PH_DONE, PH_IGNORE
  } phase_e;

  typedef enum logic [2:0] {
    TX_ZERO, TX_HDR, TX_DATA, TX_CODE, TX_SHIFT
  } txsel_e;

  typedef struct packed {
    logic       clr;
    logic       sample;
    logic       capHdr;
    logic       load;
    txsel_e     txSel;
    logic [2:0] bitPos;
    logic       useFail;
  } dp_strobe_t;
endpackage

// File: rtl/vreg_read_ctrl.sv
module vreg_read_ctrl
  import vreg_read_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                spiClk,
  input  logic                spiCsN,
  input  logic                spiMosi,
  input  logic [DEV_W-1:0]    devId,
  input  logic [BYTE_W-1:0]   rxByte,
  input  logic                txMsb,
  input  logic                echoMatch,
  output dp_strobe_t          stb,
  output logic                siS,
  output logic                csS,
  output phase_e              phase,
  output logic [CNT_W-1:0]    idx,
  output logic [CNT_W-1:0]    cnt,
  output logic                failFlag
);
  localparam int PIN_N = 3;

  logic [PIN_N-1:0] syncQ [SYNC_STAGES];
  logic sclkS, sclkPrev, rise, fall, lastData;
  logic [2:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= 3'b010;
      sclkPrev <= 1'b0;
    end else begin
      syncQ[0] <= {spiClk, spiCsN, spiMosi};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      sclkPrev <= sclkS;
    end
  end

  assign sclkS = syncQ[SYNC_STAGES-1][2];
  assign csS   = syncQ[SYNC_STAGES-1][1];
  assign siS   = syncQ[SYNC_STAGES-1][0];
  assign rise  = sclkS & ~sclkPrev & ~csS;
  assign fall  = ~sclkS & sclkPrev & ~csS;

  // the count is only known once the count code byte itself completes
  assign lastData = (idx == '0) ? (rxByte[7:4] == '0) : (idx == cnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_HDR; bitCnt <= '0; idx <= '0; cnt <= '0; failFlag <= 1'b0;
    end else if (csS) begin
      phase <= PH_HDR; bitCnt <= '0; idx <= '0; cnt <= '0; failFlag <= 1'b0;
    end else if (rise) begin
      bitCnt <= bitCnt + 3'd1;
      if (phase == PH_CTRL && siS != txMsb) failFlag <= 1'b1;
      if (bitCnt == 3'd7) begin
        unique case (phase)
          PH_HDR: phase <= (rxByte[7:6] == devId && rxByte[0]) ? PH_ADDR : PH_IGNORE;
          PH_ADDR: begin phase <= PH_DATA; idx <= '0; end
          PH_DATA: begin
            if (idx == '0) begin
              cnt <= rxByte[7:4];
              if (rxByte[3:0] != ~rxByte[7:4]) failFlag <= 1'b1;
            end
            if (lastData) begin phase <= PH_ECHO; idx <= '0; end
            else idx <= idx + 1'b1;
          end
          PH_ECHO: begin
            if (!echoMatch) failFlag <= 1'b1;
            if (idx == cnt) phase <= PH_ADDR2;
            else idx <= idx + 1'b1;
          end
          PH_ADDR2: phase <= PH_CTRL;
          PH_CTRL:  phase <= PH_DONE;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    stb.clr     = csS;
    stb.sample  = rise;
    stb.capHdr  = rise && bitCnt == 3'd7 && phase == PH_HDR;
    stb.load    = fall;
    stb.bitPos  = bitCnt;
    stb.useFail = failFlag;
    if (phase == PH_CTRL) stb.txSel = TX_CODE;
    else if (bitCnt != 3'd0) stb.txSel = TX_SHIFT;
    else begin
      unique case (phase)
        PH_ADDR, PH_ADDR2: stb.txSel = TX_HDR;
        PH_DATA:           stb.txSel = TX_DATA;
        default:           stb.txSel = TX_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/vreg_read_dp.sv
module vreg_read_dp
  import vreg_read_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PASS_CODE = 8'h59
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_strobe_t          stb,
  input  logic                siS,
  input  logic [CNT_W-1:0]    idx,
  input  logic [BYTE_W-1:0]   rdData,
  output logic [BYTE_W-1:0]   rxByte,
  output logic [BYTE_W-1:0]   hdrByte,
  output logic                txMsb,
  output logic                echoMatch,
  output logic [REG_AW-1:0]   rdAddr,
  output logic                miso
);
  localparam logic [BYTE_W-1:0] FAIL_CODE = ~PASS_CODE;

  logic [BYTE_W-1:0] rxShift, txShift, txNext, code;

  assign rxByte    = {rxShift[BYTE_W-2:0], siS};
  assign rdAddr    = hdrByte[REG_AW:1] + REG_AW'(idx);
  assign echoMatch = (rxByte == rdData);
  assign txMsb     = txShift[BYTE_W-1];
  assign miso      = ~stb.clr & txMsb;
  assign code      = stb.useFail ? FAIL_CODE : PASS_CODE;

  always_comb begin
    unique case (stb.txSel)
      TX_HDR:   txNext = hdrByte;
      TX_DATA:  txNext = rdData;
      TX_CODE:  txNext = code << stb.bitPos;
      TX_SHIFT: txNext = txShift << 1;
      default:  txNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0; txShift <= '0; hdrByte <= '0;
    end else if (stb.clr) begin
      rxShift <= '0; txShift <= '0;
    end else begin
      if (stb.sample) rxShift <= rxByte;
      if (stb.capHdr) hdrByte <= rxByte;
      if (stb.load)   txShift <= txNext;
    end
  end
endmodule

// File: rtl/vreg_read_slave.sv
module vreg_read_slave
  import vreg_read_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] PASS_CODE   = 8'h59
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEV_W-1:0]  devId,
  input  logic              spiClk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic [REG_AW-1:0] rdAddr,
  input  logic [BYTE_W-1:0] rdData
);
  dp_strobe_t        stb;
  phase_e            phase;
  logic              siS, csS, txMsb, echoMatch, failFlag;
  logic [CNT_W-1:0]  idx, cnt;
  logic [BYTE_W-1:0] rxByte, hdrByte;

  vreg_read_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .devId(devId), .rxByte(rxByte), .txMsb(txMsb), .echoMatch(echoMatch),
    .stb(stb), .siS(siS), .csS(csS), .phase(phase), .idx(idx), .cnt(cnt),
    .failFlag(failFlag)
  );

  vreg_read_dp #(.PASS_CODE(PASS_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .siS(siS), .idx(idx), .rdData(rdData),
    .rxByte(rxByte), .hdrByte(hdrByte), .txMsb(txMsb), .echoMatch(echoMatch),
    .rdAddr(rdAddr), .miso(spiMiso)
  );
endmodule

// File: rtl/vreg_read_checker.sv
module vreg_read_checker
  import vreg_read_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              spiCsN,
  input logic              spiMiso,
  input logic              csS,
  input phase_e            phase,
  input logic [CNT_W-1:0]  idx,
  input logic [CNT_W-1:0]  cnt,
  input logic              failFlag,
  input logic [BYTE_W-1:0] hdrByte
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (spiCsN && $past(spiCsN) && $past(spiCsN, 2) && $past(spiCsN, 3)) |-> !spiMiso);

  a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IGNORE) |-> !spiMiso);

  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_DATA && idx != '0) || phase == PH_ECHO) |-> (idx <= cnt));

  a_r3_hdr_held: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_HDR && $past(phase) != PH_HDR) |-> $stable(hdrByte));

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !csS) |=> (failFlag || csS));
endmodule

bind vreg_read_slave vreg_read_checker u_chk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiMiso(spiMiso), .csS(csS),
  .phase(phase), .idx(idx), .cnt(cnt), .failFlag(failFlag), .hdrByte(hdrByte)
);

// File: tb/vreg_read_slave_bench.sv
module vreg_read_slave_bench;
  localparam int HALF = 64;

  logic clk = 1'b0, rstN = 1'b0;
  logic spiClk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic [1:0] devId = 2'b10;
  logic spiMiso;
  logic [4:0] rdAddr;
  logic [7:0] rdData;
  logic [7:0] resp [0:63];
  int testsRun = 0, testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] regVal(input logic [4:0] a);
    return ({3'b000, a} * 8'd37) ^ 8'hC3;
  endfunction

  assign rdData = regVal(rdAddr);

  vreg_read_slave u_vreg_read_slave (
    .clk(clk), .rstN(rstN), .devId(devId), .spiClk(spiClk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic spiXfer(input logic [7:0] tx, input bit spike, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spiMosi = tx[i];
      #HALF;
      rx[i] = spiMiso;
      spiClk = 1'b1;
      #HALF;
      spiClk = 1'b0;
      if (spike && i == 7) begin
        #32 spiClk = 1'b1;
        #32 spiClk = 1'b0;
      end
    end
  endtask

  task automatic deselect();
    #HALF;
    spiCsN = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  // master side of a read: header, 0x00, count code, zeros, echo, 0x00, verdict byte
  task automatic runRead(input logic [1:0] dev, input logic [4:0] sreg, input bit rnw,
                         input logic [7:0] cntCode, input int n, input int badEcho,
                         input bit spike, input bit early);
    logic [7:0] hdr, r;
    int k;
    hdr = {dev, sreg, rnw};
    @(negedge clk);
    spiCsN = 1'b0;
    k = 0;
    spiXfer(hdr, 1'b0, r);  resp[k] = r; k++;
    spiXfer(8'h00, 1'b0, r); resp[k] = r; k++;
    spiXfer(cntCode, 1'b0, r); resp[k] = r; k++;
    for (int i = 1; i < n; i++) begin spiXfer(8'h00, 1'b0, r); resp[k] = r; k++; end
    if (!early) begin
      for (int i = 0; i < n; i++) begin
        spiXfer((i == badEcho) ? ~resp[2+i] : resp[2+i], 1'b0, r); resp[k] = r; k++;
      end
      spiXfer(8'h00, 1'b0, r); resp[k] = r; k++;
      spiXfer(8'h59, spike, r); resp[k] = r; k++;
      repeat (8) @(negedge clk);
      check(spiMiso == 1'b0, "R11 quiet after verdict", {7'd0, spiMiso}, 8'h00);
    end
    deselect();
  endtask

  task automatic testReset();
    check(spiMiso == 1'b0, "R1 idle after reset", {7'd0, spiMiso}, 8'h00);
  endtask

  task automatic testSingle();
    logic [7:0] hdr;
    hdr = {2'b10, 5'd5, 1'b1};
    runRead(2'b10, 5'd5, 1'b1, 8'h0F, 1, -1, 1'b0, 1'b0);
    check(resp[0] == 8'h00, "R1 header slot zero", resp[0], 8'h00);
    check(resp[1] == hdr, "R3 header echo", resp[1], hdr);
    check(resp[2] == regVal(5), "R4 single data", resp[2], regVal(5));
    check(resp[3] == 8'h00, "R7 zero during echo", resp[3], 8'h00);
    check(resp[4] == hdr, "R7 second header echo", resp[4], hdr);
    check(resp[5] == 8'h59, "R8 pass verdict", resp[5], 8'h59);
  endtask

  task automatic testMultiWrap();
    runRead(2'b10, 5'd30, 1'b1, 8'h3C, 4, -1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++)
      check(resp[2+i] == regVal(5'(30 + i)), "R4 R5 wrap stream", resp[2+i], regVal(5'(30 + i)));
    check(resp[6] == 8'h00, "R7 zero during echo", resp[6], 8'h00);
    check(resp[11] == 8'h59, "R5 four-byte pass", resp[11], 8'h59);
  endtask

  task automatic testIgnored();
    logic [7:0] orv;
    runRead(2'b01, 5'd3, 1'b1, 8'h0F, 1, -1, 1'b0, 1'b0);
    orv = resp[0] | resp[1] | resp[2] | resp[3] | resp[4] | resp[5];
    check(orv == 8'h00, "R2 other device silent", orv, 8'h00);
    runRead(2'b10, 5'd3, 1'b0, 8'h0F, 1, -1, 1'b0, 1'b0);
    orv = resp[0] | resp[1] | resp[2] | resp[3] | resp[4] | resp[5];
    check(orv == 8'h00, "R2 write header silent", orv, 8'h00);
  endtask

  task automatic testBadCount();
    runRead(2'b10, 5'd9, 1'b1, 8'h1F, 2, -1, 1'b0, 1'b0);
    check(resp[3] == regVal(10), "R6 data still sent", resp[3], regVal(10));
    check(resp[7] == 8'hA6, "R6 bad count verdict", resp[7], 8'hA6);
  endtask

  task automatic testBadEcho();
    runRead(2'b10, 5'd12, 1'b1, 8'h1E, 2, 1, 1'b0, 1'b0);
    check(resp[7] == 8'hA6, "R8 echo mismatch verdict", resp[7], 8'hA6);
  endtask

  task automatic testSpike();
    runRead(2'b10, 5'd7, 1'b1, 8'h0F, 1, -1, 1'b1, 1'b0);
    check(resp[5] != 8'h59, "R9 spike breaks verdict", resp[5], 8'hA6);
  endtask

  task automatic testEarly();
    runRead(2'b10, 5'd20, 1'b1, 8'h1E, 2, -1, 1'b0, 1'b1);
    check(resp[3] == regVal(21), "R10 data before release", resp[3], regVal(21));
    check(spiMiso == 1'b0, "R10 idle after release", {7'd0, spiMiso}, 8'h00);
    runRead(2'b10, 5'd0, 1'b1, 8'h0F, 1, -1, 1'b0, 1'b0);
    check(resp[2] == regVal(0), "R10 next read data", resp[2], regVal(0));
    check(resp[5] == 8'h59, "R10 next read passes", resp[5], 8'h59);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testSingle();
    testMultiWrap();
    testIgnored();
    testBadCount();
    testBadEcho();
    testSpike();
    testEarly();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule